// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. A 16-bit up-counter advances once per tick of a programmable prescaler. When the count passes 0xFFFF it wraps to zero, latches an overflow flag and drives a reset-request pulse for a fixed number of system clocks. Software keeps the system alive by loading a fresh count before the counter wraps.

No register changes unless the write carries a fixed key pattern in its upper data bits. An accepted write goes into a staging register first. The value reaches the counting logic only after two prescaler ticks, and a busy flag is visible to software for that whole time. Further writes are refused until the flag drops, so a stray store or a runaway loop cannot disturb the timer in a single access.

Top module: `key_watchdog`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 (timer disabled, prescaler code 0, no flags) and `rst_req` is low.
- R2: A write to offset 0x0 is accepted only when wdata[31:16] equals 0x5A5A. The new count is wdata[15:0]. A write with any other upper half changes nothing, and the busy flag stays low.
- R3: A write to offset 0x4 is accepted only when wdata[31:8] equals 0xA5A5A5. Once applied, bit 7 becomes the enable and bits 2:0 become the prescaler code. With any other key the write changes nothing.
- R4: Busy (control bit 5) rises in the cycle after an accepted write. It stays high until the second prescaler tick after that write, and the staged value is applied on that same tick. Writes to either register are ignored while busy is high.
- R5: Prescaler codes 0 to 7 give one tick every 1, 4, 16, 32, 64, 128, 1024 and 4096 clocks. The counter advances by one on each tick while enable is set.
- R6: When the count wraps from 0xFFFF to 0, the overflow flag (control bit 4) sets and `rst_req` is high for exactly 4 clocks. The counter keeps counting from 0.
- R7: A key-valid control write with bit 4 at 0 clears the overflow flag. Writing 1 to bit 4 leaves the flag as it was.
- R8: Reads are combinational. Offset 0x0 returns {16'h0, count}. Offset 0x4 returns {24'h0, enable, 0, busy, overflow, 0, code}. Every other offset returns 0.
- R9: While enable is clear the count holds its value, and the prescaler keeps running so that staged writes still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data including key field |
| bus_rdata | output | 32 | Read data for bus_addr |
| rst_req | output | 1 | Reset request pulse on overflow |

## Verification
The overflow and its reset pulse are the hardest conditions to reach from the ports, because starting from zero they need 65536 ticks. The bench loads the counter with 0xFFFA through a key-valid write, enables the fastest prescaler, then measures the pulse length and the count that follows the wrap. The second difficult case is a write that arrives while busy is high. It needs two back-to-back bus cycles that land inside the staging window, and the bench checks that only the first value is applied.

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter int ADDR_W     = 4,
  parameter int DIV_W      = 12,
  parameter int PULSE_CYC  = 4,
  parameter int HOLD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  localparam int CNT_W = 16;
  localparam int PW    = $clog2(PULSE_CYC + 1);
  localparam int HW    = $clog2(HOLD_TICKS + 1);
  localparam logic [15:0] CNT_KEY = 16'h5A5A;
  localparam logic [23:0] CTL_KEY = 24'hA5A5A5;
  localparam logic [ADDR_W-1:0] OFS_CNT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(4);

  function automatic logic [DIV_W-1:0] div_limit(input logic [2:0] code);
    case (code)
      3'd0:    div_limit = DIV_W'(0);
      3'd1:    div_limit = DIV_W'(3);
      3'd2:    div_limit = DIV_W'(15);
      3'd3:    div_limit = DIV_W'(31);
      3'd4:    div_limit = DIV_W'(63);
      3'd5:    div_limit = DIV_W'(127);
      3'd6:    div_limit = DIV_W'(1023);
      default: div_limit = DIV_W'(4095);
    endcase
  endfunction

  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] cnt;
  logic             en, ovf, busy, stage_ctl;
  logic [2:0]       cks;
  logic [CNT_W-1:0] stage_val;
  logic [HW-1:0]    stage_n;
  logic [PW-1:0]    pulse;

  wire tick    = div_cnt >= div_limit(cks);
  wire wr      = bus_sel && bus_we && !busy;
  wire acc_cnt = wr && bus_addr == OFS_CNT && bus_wdata[31:16] == CNT_KEY;
  wire acc_ctl = wr && bus_addr == OFS_CTL && bus_wdata[31:8] == CTL_KEY;
  wire apply   = busy && tick && stage_n == HW'(HOLD_TICKS - 1);
  wire ld_cnt  = apply && !stage_ctl;
  wire ld_ctl  = apply && stage_ctl;
  wire wrap    = tick && en && cnt == '1 && !ld_cnt;

  assign rst_req = pulse != '0;

  always_comb begin
    case (bus_addr)
      OFS_CNT: bus_rdata = {16'h0, cnt};
      OFS_CTL: bus_rdata = {24'h0, en, 1'b0, busy, ovf, 1'b0, cks};
      default: bus_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      stage_ctl <= 1'b0;
      stage_val <= '0;
      stage_n   <= '0;
    end else if (acc_cnt || acc_ctl) begin
      busy      <= 1'b1;
      stage_ctl <= acc_ctl;
      stage_val <= bus_wdata[15:0];
      stage_n   <= '0;
    end else if (busy && tick) begin
      if (apply) busy <= 1'b0;
      else       stage_n <= stage_n + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           cnt <= '0;
    else if (ld_cnt)      cnt <= stage_val;
    else if (tick && en)  cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cks <= 3'd0;
      ovf <= 1'b0;
    end else begin
      if (ld_ctl) begin
        en  <= stage_val[7];
        cks <= stage_val[2:0];
        if (!stage_val[4]) ovf <= 1'b0;
      end
      if (wrap) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          pulse <= '0;
    else if (wrap)       pulse <= PW'(PULSE_CYC);
    else if (rst_req)    pulse <= pulse - 1'b1;
endmodule

module key_watchdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_req,
  input logic        busy,
  input logic        ovf,
  input logic        en,
  input logic        tick,
  input logic [15:0] cnt
);
  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (ovf && cnt == 16'h0));
  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> $past(rst_req, 4));
  // R6
  ovf_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(en));
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> $stable(cnt));
  // R5
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !busy) |=> $stable(cnt));
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
endmodule

bind key_watchdog key_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .busy(busy),
  .ovf(ovf), .en(en), .tick(tick), .cnt(cnt)
);

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic rst_req;
  int total = 0, bad = 0;
  int cyc = 0;
  bit done = 0;

  key_watchdog dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata; bus_addr = 4'h0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(4'h4, v);
      if (!v[5]) return;
    end
    chk("R4 busy timeout", 32'h1, 32'h0);
  endtask

  function automatic int ratio(input int k);
    if (k == 0) return 1;
    if (k == 1) return 4;
    if (k <= 5) return 1 << (k + 2);
    return 1 << (2 * k - 2);
  endfunction

  initial begin
    repeat (10000 * 20) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int t[3];
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, v); chk("R1 count", v, 32'h0);
    rd(4'h4, v); chk("R1 control", v, 32'h0);
    chk("R1 rst_req", {31'h0, rst_req}, 32'h0);

    // R2/R3 key sweep: every single-bit key corruption is rejected
    for (int b = 16; b < 32; b++) begin
      wr(4'h0, (32'h5A5A_0077 ^ (32'h1 << b)));
      rd(4'h4, v); chk("R2 bad key busy", {31'h0, v[5]}, 32'h0);
    end
    for (int b = 8; b < 32; b++) begin
      wr(4'h4, (32'hA5A5_A587 ^ (32'h1 << b)));
      rd(4'h4, v); chk("R3 bad key busy", {31'h0, v[5]}, 32'h0);
    end
    repeat (3) @(negedge clk);
    rd(4'h0, v); chk("R2 count unchanged", v, 32'h0);
    rd(4'h4, v); chk("R3 control unchanged", v, 32'h0);

    // R2/R4 accepted counter write timing (ratio 1)
    wr(4'h0, 32'h5A5A_0042);
    rd(4'h4, v); chk("R4 busy after accept", {31'h0, v[5]}, 32'h1);
    rd(4'h0, v); chk("R4 not yet applied", v, 32'h0);
    @(negedge clk);
    rd(4'h4, v); chk("R4 busy after one tick", {31'h0, v[5]}, 32'h1);
    @(negedge clk);
    rd(4'h4, v); chk("R4 busy clear after two ticks", {31'h0, v[5]}, 32'h0);
    rd(4'h0, v); chk("R2 count loaded", v, 32'h42);

    // R4 write while busy is ignored
    wr(4'h0, 32'h5A5A_0100);
    wr(4'h0, 32'h5A5A_0200);
    repeat (3) @(negedge clk);
    rd(4'h0, v); chk("R4 second write ignored", v, 32'h100);

    // R8 read map
    rd(4'h8, v); chk("R8 offset 8 reads zero", v, 32'h0);
    rd(4'hC, v); chk("R8 offset C reads zero", v, 32'h0);

    // R9 hold while disabled
    repeat (40) @(negedge clk);
    rd(4'h0, v); chk("R9 hold disabled", v, 32'h100);

    // R5 prescaler sweep, R3 control readback
    for (int k = 0; k < 8; k++) begin
      wait_idle();
      wr(4'h0, 32'h5A5A_0000);
      wait_idle();
      wr(4'h4, 32'hA5A5_A580 | k);
      wait_idle();
      rd(4'h4, v); chk("R3 control readback", v, 32'h80 | k);
      rd(4'h0, v2);
      n = 0;
      for (int i = 0; i < 20000 && n < 3; i++) begin
        @(negedge clk);
        rd(4'h0, v);
        if (v != v2) begin t[n] = cyc; n++; v2 = v; end
      end
      chk("R5 tick interval", t[2] - t[1], ratio(k));
    end

    // disable, then R9 hold
    wait_idle();
    wr(4'h4, 32'hA5A5_A500);
    wait_idle();
    rd(4'h0, v2);
    repeat (50) @(negedge clk);
    rd(4'h0, v); chk("R9 hold after disable", v, v2);

    // R6 overflow
    wr(4'h0, 32'h5A5A_FFFA);
    wait_idle();
    wr(4'h4, 32'hA5A5_A580);
    n = 0;
    while (!rst_req && n < 100) begin @(negedge clk); n++; end
    rd(4'h0, v); chk("R6 wrapped to zero", v, 32'h0);
    rd(4'h4, v); chk("R6 overflow flag", {31'h0, v[4]}, 32'h1);
    n = 0;
    while (rst_req && n < 20) begin n++; @(negedge clk); end
    chk("R6 pulse length", n, 4);
    rd(4'h0, v); chk("R6 keeps counting", v, 32'h4);

    // R7 overflow clear semantics
    wr(4'h4, 32'hA5A5_A480);
    wait_idle();
    rd(4'h4, v); chk("R7 bad key keeps flag", {31'h0, v[4]}, 32'h1);
    wr(4'h4, 32'hA5A5_A590);
    wait_idle();
    rd(4'h4, v); chk("R7 write one keeps flag", {31'h0, v[4]}, 32'h1);
    wr(4'h4, 32'hA5A5_A580);
    wait_idle();
    rd(4'h4, v); chk("R7 write zero clears", v, 32'h80);

    // R4 counter write while enabled overrides increment
    wr(4'h0, 32'h5A5A_1000);
    @(negedge clk);
    @(negedge clk);
    rd(4'h0, v); chk("R4 applied on second tick", v, 32'h1000);
    @(negedge clk);
    rd(4'h0, v); chk("R5 counts after load", v, 32'h1001);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule